// File: doc/BRIEF.md
# Zero-Run Detector for Stereo DAC Samples

This block watches the left and right sample words headed for a stereo DAC and tells the system when either channel has been silent for a long stretch. Each channel has its own run counter. The counter advances on every valid sample that is exactly zero and restarts on any valid sample that has a bit set. When a channel has seen 1024 zero samples in a row, that channel's detection goes high. It stays high while zeros keep arriving.

The two channel detections feed a small selector that drives two zero-flag pins. A 2-bit mode chooses how the pins behave: both pins held low, each pin following its own channel, both pins showing that the two channels are silent together, or both pins showing that at least one channel is silent. The flag pins can drive an external muting circuit. A separate mute request output, gated by an auto-mute enable, goes high while any channel is detected silent.

The flag and mute outputs follow the registered detections and the mode inputs with no extra register stage. A change of mode or auto-mute enable therefore shows at the outputs in the same cycle.

Top module: `zero_run_detector`

## Requirements
- R1: While reset (rstN low) is asserted, and in the cycle after it is released, both detections are clear and zeroFlagLeft, zeroFlagRight and muteReq are 0. A reset in the middle of a run discards that run.
- R2: A channel's detection rises at the clock edge that takes in its 1024th consecutive valid zero sample, and is visible right after that edge. After only 1023 valid zeros the detection is still low.
- R3: Samples presented while sampleValid is 0 are ignored. They neither advance nor break a run, and they do not clear an existing detection.
- R4: A valid sample with any bit set clears that channel's run and its detection at the same edge, with no effect on the other channel. After a clear, a new run of 1024 valid zeros is needed before the detection rises again.
- R5: The run count saturates. A channel that keeps receiving valid zeros past 1024 keeps its detection high and never wraps.
- R6: flagMode = 2'b00 holds both zeroFlagLeft and zeroFlagRight at 0.
- R7: flagMode = 2'b01 drives zeroFlagLeft from the left detection and zeroFlagRight from the right detection.
- R8: flagMode = 2'b10 drives both flags high only when both channels are detected silent.
- R9: flagMode = 2'b11 drives both flags high when at least one channel is detected silent.
- R10: muteReq equals autoMuteEn AND (left detection OR right detection), whatever the value of flagMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | High in cycles that carry a new sample pair |
| sampleLeft | input | SAMPLE_W | Left channel sample word |
| sampleRight | input | SAMPLE_W | Right channel sample word |
| flagMode | input | 2 | Flag behaviour: 00 off, 01 per channel, 10 both silent, 11 any silent |
| autoMuteEn | input | 1 | Allows a silence detection to raise muteReq |
| zeroFlagLeft | output | 1 | Left zero flag, 1 means silence detected |
| zeroFlagRight | output | 1 | Right zero flag, 1 means silence detected |
| muteReq | output | 1 | Automatic mute request |

## Verification
The bench probes the threshold from both sides. A run of 1023 zeros must leave the flags low and a run of 1024 must raise them, so an off-by-one counter shows up at once. Runs of about 2000 zeros check saturation: a counter that wraps would drop its detection part way through. The bench also stalls sampleValid with nonzero data on the bus in the middle of a run and after a detection. A design that looks at samples without checking the strobe would break the run or clear the flag. It then sends a single nonzero word to one channel, which catches clears that leak to the other channel or that fail to restart the count. Every flag mode and the mute gating are checked against the expected pin values, including the case where the flags are off while muteReq is high.

// File: rtl/zdet_pkg.sv
package zdet_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;

  typedef struct packed {
    logic [NUM_CH-1:0] advance;
    logic [NUM_CH-1:0] clear;
  } runStrobe_t;

  typedef enum logic [1:0] {
    FLAG_OFF   = 2'b00,
    FLAG_SPLIT = 2'b01,
    FLAG_BOTH  = 2'b10,
    FLAG_ANY   = 2'b11
  } flagMode_e;
endpackage

// File: rtl/zdet_datapath.sv
module zdet_datapath
  import zdet_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  runStrobe_t          strobe,
  output logic [NUM_CH-1:0]   isZero,
  output logic [NUM_CH-1:0]   detect
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

  logic [SAMPLE_W-1:0] chSample [NUM_CH];
  assign chSample[CH_L] = sampleLeft;
  assign chSample[CH_R] = sampleRight;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] runCnt;

    assign isZero[ch] = (chSample[ch] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (strobe.clear[ch]) begin
        runCnt <= '0;
      end else if (strobe.advance[ch] && (runCnt != FULL)) begin
        runCnt <= runCnt + 1'b1;
      end
    end

    assign detect[ch] = (runCnt == FULL);

    // R5: a detection survives further zeros (no wrap)
    a_r5_no_wrap : assert property (@(posedge clk) disable iff (!rstN)
      (detect[ch] && !strobe.clear[ch]) |=> detect[ch]);

    // R4: a clear strobe always drops the detection
    a_r4_clear_drops : assert property (@(posedge clk) disable iff (!rstN)
      strobe.clear[ch] |=> !detect[ch]);

    // R2: detection may only rise after a counted zero sample
    a_r2_rise_on_zero : assert property (@(posedge clk) disable iff (!rstN)
      $rose(detect[ch]) |-> $past(strobe.advance[ch]));
  end
endmodule

// File: rtl/zdet_control.sv
module zdet_control
  import zdet_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [NUM_CH-1:0] isZero,
  input  logic [NUM_CH-1:0] detect,
  input  logic [1:0]        flagMode,
  input  logic              autoMuteEn,
  output runStrobe_t        strobe,
  output logic              flagLeft,
  output logic              flagRight,
  output logic              muteReq
);
  flagMode_e modeSel;
  assign modeSel = flagMode_e'(flagMode);

  always_comb begin
    strobe.advance = {NUM_CH{sampleValid}} & isZero;
    strobe.clear   = {NUM_CH{sampleValid}} & ~isZero;
  end

  logic bothSilent;
  logic anySilent;
  assign bothSilent = &detect;
  assign anySilent  = |detect;

  always_comb begin
    unique case (modeSel)
      FLAG_OFF: begin
        flagLeft  = 1'b0;
        flagRight = 1'b0;
      end
      FLAG_SPLIT: begin
        flagLeft  = detect[CH_L];
        flagRight = detect[CH_R];
      end
      FLAG_BOTH: begin
        flagLeft  = bothSilent;
        flagRight = bothSilent;
      end
      default: begin
        flagLeft  = anySilent;
        flagRight = anySilent;
      end
    endcase
  end

  assign muteReq = autoMuteEn & anySilent;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R3: no strobe of either kind without a valid sample
    a_r3_idle_quiet : assert property (@(posedge clk) disable iff (!rstN)
      !sampleValid |-> !(strobe.advance[ch] || strobe.clear[ch]));
    // R4: advance and clear never together
    a_r4_exclusive : assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.advance[ch] && strobe.clear[ch]));
  end

  // R6: flags off in mode 00
  a_r6_off_low : assert property (@(posedge clk) disable iff (!rstN)
    (flagMode == 2'b00) |-> !(flagLeft || flagRight));
  // R8/R9: combined modes drive both pins alike
  a_r8_pins_match : assert property (@(posedge clk) disable iff (!rstN)
    flagMode[1] |-> (flagLeft == flagRight));
  // R10: mute gated by enable
  a_r10_mute_gated : assert property (@(posedge clk) disable iff (!rstN)
    !autoMuteEn |-> !muteReq);
  // R10: mute requires a detection somewhere
  a_r10_mute_cause : assert property (@(posedge clk) disable iff (!rstN)
    muteReq |-> (detect != '0));
endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector
  import zdet_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic [1:0]          flagMode,
  input  logic                autoMuteEn,
  output logic                zeroFlagLeft,
  output logic                zeroFlagRight,
  output logic                muteReq
);
  runStrobe_t        strobe;
  logic [NUM_CH-1:0] isZero;
  logic [NUM_CH-1:0] detect;

  zdet_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .isZero     (isZero),
    .detect     (detect),
    .flagMode   (flagMode),
    .autoMuteEn (autoMuteEn),
    .strobe     (strobe),
    .flagLeft   (zeroFlagLeft),
    .flagRight  (zeroFlagRight),
    .muteReq    (muteReq)
  );

  zdet_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .RUN_LEN (RUN_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleLeft (sampleLeft),
    .sampleRight(sampleRight),
    .strobe     (strobe),
    .isZero     (isZero),
    .detect     (detect)
  );
endmodule

// File: tb/zero_run_detector_tb_top.sv
module zero_run_detector_tb_top;
  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleLeft = '0;
  logic [SW-1:0] sampleRight = '0;
  logic [1:0]    flagMode = 2'b11;
  logic          autoMuteEn = 1'b1;
  logic          zeroFlagLeft, zeroFlagRight, muteReq;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  zero_run_detector #(.SAMPLE_W(SW), .RUN_LEN(1024)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .flagMode(flagMode), .autoMuteEn(autoMuteEn),
    .zeroFlagLeft(zeroFlagLeft), .zeroFlagRight(zeroFlagRight), .muteReq(muteReq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        am;
    logic [11:0] runL;
    logic [11:0] runR;
    logic        expL;
    logic        expR;
    logic        expM;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 12'd1024, 12'd0,    1'b1, 1'b0, 1'b0}, // R7 R2
    '{2'b01, 1'b1, 12'd0,    12'd1024, 1'b0, 1'b1, 1'b1}, // R7 R10
    '{2'b01, 1'b1, 12'd1023, 12'd1023, 1'b0, 1'b0, 1'b0}, // R2 boundary
    '{2'b10, 1'b0, 12'd1024, 12'd1024, 1'b1, 1'b1, 1'b0}, // R8
    '{2'b10, 1'b1, 12'd1024, 12'd500,  1'b0, 1'b0, 1'b1}, // R8 R10
    '{2'b11, 1'b0, 12'd1024, 12'd0,    1'b1, 1'b1, 1'b0}, // R9
    '{2'b11, 1'b0, 12'd0,    12'd0,    1'b0, 1'b0, 1'b0}, // R9
    '{2'b00, 1'b1, 12'd1024, 12'd1024, 1'b0, 1'b0, 1'b1}, // R6 R10
    '{2'b11, 1'b1, 12'd2000, 12'd2000, 1'b1, 1'b1, 1'b1}  // R5
  };

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkPins(input string req, input logic eL, input logic eR, input logic eM);
    check({req, " zeroFlagLeft"}, zeroFlagLeft, eL);
    check({req, " zeroFlagRight"}, zeroFlagRight, eR);
    check({req, " muteReq"}, muteReq, eM);
  endtask

  task automatic drive(input logic v, input logic [SW-1:0] l, input logic [SW-1:0] r);
    @(negedge clk);
    sampleValid = v;
    sampleLeft  = l;
    sampleRight = r;
  endtask

  // one leading nonzero pair, then each channel ends on its requested zero run
  task automatic feed(input int runL, input int runR);
    int total;
    total = ((runL > runR) ? runL : runR) + 1;
    for (int k = 0; k < total; k++) begin
      drive(1'b1, (k < total - runL) ? 24'h800000 : '0,
                  (k < total - runR) ? 24'h000001 : '0);
    end
    drive(1'b0, 24'h0F0F0F, 24'h0F0F0F);
  endtask

  task automatic zeros(input int n);
    for (int k = 0; k < n; k++) drive(1'b1, '0, '0);
    drive(1'b0, 24'h000100, 24'h000100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkPins("R1 in reset", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkPins("R1 after release", 1'b0, 1'b0, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      flagMode   = VECS[i].mode;
      autoMuteEn = VECS[i].am;
      feed(int'(VECS[i].runL), int'(VECS[i].runR));
      checkPins($sformatf("R2 R5-R10 vector %0d", i), VECS[i].expL, VECS[i].expR, VECS[i].expM);
    end

    // R3: idle cycles with nonzero data do not break a run
    flagMode = 2'b01; autoMuteEn = 1'b0;
    feed(0, 0);
    for (int k = 0; k < 1023; k++) drive(1'b1, '0, '0);
    for (int k = 0; k < 10; k++) drive(1'b0, 24'hFFFFFF, 24'h123456);
    drive(1'b0, 24'hFFFFFF, 24'h123456);
    checkPins("R3 run paused", 1'b0, 1'b0, 1'b0);
    zeros(1);
    checkPins("R3 run resumed", 1'b1, 1'b1, 1'b0);
    // R3: idle nonzero does not clear a detection
    for (int k = 0; k < 5; k++) drive(1'b0, 24'hABCDEF, 24'hABCDEF);
    @(negedge clk);
    checkPins("R3 detection kept", 1'b1, 1'b1, 1'b0);

    // R4: single nonzero on left only
    drive(1'b1, 24'h000040, '0);
    drive(1'b0, '0, '0);
    checkPins("R4 left cleared", 1'b0, 1'b1, 1'b0);
    zeros(1023);
    checkPins("R4 restart 1023", 1'b0, 1'b1, 1'b0);
    zeros(1);
    checkPins("R4 restart 1024", 1'b1, 1'b1, 1'b0);

    // R10: mute in per-channel mode, then enable toggled
    autoMuteEn = 1'b1;
    @(negedge clk);
    check("R10 mute on", muteReq, 1'b1);
    autoMuteEn = 1'b0;
    @(negedge clk);
    check("R10 mute off", muteReq, 1'b0);

    // R1: reset mid-detection clears
    autoMuteEn = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkPins("R1 reset clears", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    zeros(1023);
    checkPins("R1 run restarted", 1'b0, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule